// File: doc/BRIEF.md
# D-Channel Contention Controller

This block arbitrates access to the shared signalling channel of a basic-rate time-division line bus. The upstream logic writes a complete, already flag-delimited and bit-stuffed D-channel bit stream into a small local frame store, one bit per cycle. Once that frame is committed, the block raises a request line to the line interface device. It then waits for a frame sync on which the device also shows its grant.

From that frame on, the block places one stored bit on the transmit line in every D-channel bit slot. It begins with the first bit of the store, which is the leading zero of the opening flag. If the grant is withdrawn while the frame is going out, the block treats this as a collision and releases the line in the same cycle. When the collision came early enough, the block keeps its request up and waits for the grant to show again at a sync, then replays the frame from its first bit. A collision later in the frame discards the frame and gives an error pulse. After the final bit of the closing flag, the block drops its request and gives a single-cycle completion pulse.

The frame is viewed as a run of fixed-size buffers of `BUF_BITS` bits. Only a collision that falls inside the first two buffers is retried.

Top module: `dch_contention_ctrl`

## Requirements
- R1: `req_o` is high from the cycle after a frame is committed until the frame ends, including while waiting for the grant and while backing off after a retried collision. It is low otherwise, and it falls only in the cycle where `done_o` or `err_o` is high.
- R2: The grant is looked at only in a cycle where `sync_i` is high (active high). A grant that rises between syncs drives no bit until the next sync that finds it high.
- R3: After a start, the stored bits go out in write order, bit 0 first. One bit is sent per cycle in which `dslot_i` is high (active high) and the grant holds, starting with the first such cycle after the starting sync. `txd_oe_o` is high exactly when `txd_o` carries a bit.
- R4: Outside a sending frame, and outside D-channel slots, `txd_oe_o` is low and `txd_o` is high impedance.
- R5: A low grant while sending stops the output in that same cycle, so `txd_oe_o` is low and nothing further is sent from the current pass.
- R6: A collision after fewer than 2*`BUF_BITS` bits of the current pass have been sent keeps `req_o` high. The whole frame is then resent from bit 0 once a sync finds the grant high.
- R7: A collision after 2*`BUF_BITS` or more bits have been sent discards the frame. `err_o` is high for exactly the next cycle, `req_o` is low in that cycle, and the store is freed.
- R8: In the cycle after the last stored bit is sent, `done_o` is high for one cycle, `req_o` is low, and the store is freed.
- R9: `ld_ready_o` is high only while the store holds no committed frame. A bit offered while it is low is ignored. A bit written with `ld_last_i` high commits the frame, and so does the `FRAME_BITS`-th bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Frame sync, high for one cycle per line frame |
| dslot_i | input | 1 | High in the cycle of each D-channel bit slot |
| grant_i | input | 1 | Channel grant from the line interface device |
| ld_valid_i | input | 1 | Store write strobe |
| ld_bit_i | input | 1 | Bit to store |
| ld_last_i | input | 1 | Marks the final bit of the frame |
| ld_ready_o | output | 1 | Store accepts bits |
| req_o | output | 1 | Channel request to the line interface device |
| txd_o | output | 1 | Transmit data, high impedance when not driving |
| txd_oe_o | output | 1 | Transmit data is being driven |
| done_o | output | 1 | One-cycle frame-sent pulse |
| err_o | output | 1 | One-cycle frame-aborted pulse |

## Verification
The assertions assume that `sync_i` and `dslot_i` never come high in the same cycle. They also assume that the grant only matters once a request is up, and that upstream offers bits only when it means to fill the store. The bench keeps to this by making the line timing itself from a fixed twelve-cycle frame: sync is in slot 0, and the D bits are in slots 4 and 9. Grant drops are timed against the bench model's count of bits sent, so that collisions land on chosen bit positions on both sides of the two-buffer limit. The stimulus also includes a grant that rises just after a sync, writes offered while a frame is held, and a frame that fills the store without a last marker.

// File: rtl/dch_pkg.sv
package dch_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_REQUEST = 3'd1,
    ST_SEND    = 3'd2,
    ST_BACKOFF = 3'd3,
    ST_DONE    = 3'd4
  } dch_state_e;
endpackage

// File: rtl/dch_frame_store.sv
module dch_frame_store #(
  parameter int FRAME_BITS = 64,
  localparam int ADDR_W = $clog2(FRAME_BITS),
  localparam int LEN_W  = $clog2(FRAME_BITS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic              wr_bit_i,
  input  logic              wr_last_i,
  input  logic              release_i,
  input  logic [ADDR_W-1:0] rd_idx_i,
  output logic              rd_bit_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              held_o
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] mem_q;
  logic [ADDR_W-1:0]     wr_ptr_q;
  logic [LEN_W-1:0]      len_q;
  logic                  held_q;
  logic                  commit;

  // filling the last location commits even without a marker
  assign commit = wr_valid_i && (wr_last_i || (wr_ptr_q == TOP_ADDR));

  always_ff @(posedge clk_i) begin
    if (wr_valid_i) mem_q[wr_ptr_q] <= wr_bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      len_q    <= '0;
      held_q   <= 1'b0;
    end else if (release_i) begin
      wr_ptr_q <= '0;
      held_q   <= 1'b0;
    end else if (wr_valid_i) begin
      wr_ptr_q <= wr_ptr_q + ADDR_W'(1);
      if (commit) begin
        held_q <= 1'b1;
        len_q  <= LEN_W'(wr_ptr_q) + LEN_W'(1);
      end
    end
  end

  assign rd_bit_o = mem_q[rd_idx_i];
  assign len_o    = len_q;
  assign held_o   = held_q;
endmodule

// File: rtl/dch_tx_cursor.sv
module dch_tx_cursor #(
  parameter int FRAME_BITS = 64,
  parameter int BUF_BITS   = 16,
  localparam int ADDR_W = $clog2(FRAME_BITS),
  localparam int LEN_W  = $clog2(FRAME_BITS + 1),
  localparam int RETRY_LIMIT = 2 * BUF_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rewind_i,
  input  logic              step_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [ADDR_W-1:0] idx_o,
  output logic              last_o,
  output logic              early_o
);
  logic [ADDR_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       idx_q <= '0;
    else if (rewind_i) idx_q <= '0;
    else if (step_i)   idx_q <= idx_q + ADDR_W'(1);
  end

  generate
    if (RETRY_LIMIT >= FRAME_BITS) begin : g_all_early
      assign early_o = 1'b1;
    end else begin : g_cmp_early
      assign early_o = (idx_q < ADDR_W'(RETRY_LIMIT));
    end
  endgenerate

  assign last_o = ((LEN_W'(idx_q) + LEN_W'(1)) == len_i);
  assign idx_o  = idx_q;
endmodule

// File: rtl/dch_arb_fsm.sv
module dch_arb_fsm
  import dch_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       held_i,
  input  logic       sync_i,
  input  logic       dslot_i,
  input  logic       grant_i,
  input  logic       last_i,
  input  logic       early_i,
  output dch_state_e state_o,
  output logic       rewind_o,
  output logic       step_o,
  output logic       release_o,
  output logic       tx_en_o,
  output logic       req_o,
  output logic       done_o,
  output logic       err_o
);
  dch_state_e state_q, state_d;
  logic       err_q;
  logic       collide, abort, start;

  assign start   = (state_q == ST_REQUEST || state_q == ST_BACKOFF) && sync_i && grant_i;
  assign collide = (state_q == ST_SEND) && !grant_i;
  assign abort   = collide && !early_i;
  assign tx_en_o = (state_q == ST_SEND) && grant_i && dslot_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (held_i) state_d = ST_REQUEST;
      ST_REQUEST,
      ST_BACKOFF: if (start) state_d = ST_SEND;
      ST_SEND: begin
        if (collide)                state_d = early_i ? ST_BACKOFF : ST_IDLE;
        else if (tx_en_o && last_i) state_d = ST_DONE;
      end
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= abort;
    end
  end

  assign rewind_o  = start;
  assign step_o    = tx_en_o && !last_i;
  assign release_o = (state_q == ST_DONE) || abort;
  assign req_o     = (state_q == ST_REQUEST) || (state_q == ST_SEND) || (state_q == ST_BACKOFF);
  assign done_o    = (state_q == ST_DONE);
  assign err_o     = err_q;
  assign state_o   = state_q;
endmodule

// File: rtl/dch_contention_ctrl.sv
module dch_contention_ctrl
  import dch_pkg::*;
#(
  parameter int FRAME_BITS = 64,
  parameter int BUF_BITS   = 16,
  localparam int ADDR_W = $clog2(FRAME_BITS),
  localparam int LEN_W  = $clog2(FRAME_BITS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic dslot_i,
  input  logic grant_i,
  input  logic ld_valid_i,
  input  logic ld_bit_i,
  input  logic ld_last_i,
  output logic ld_ready_o,
  output logic req_o,
  output logic txd_o,
  output logic txd_oe_o,
  output logic done_o,
  output logic err_o
);
  dch_state_e        fsm_state;
  logic [ADDR_W-1:0] cur_idx;
  logic [LEN_W-1:0]  frame_len;
  logic              held, rd_bit, last, early;
  logic              rewind, step, release_buf, tx_en;

  assign ld_ready_o = !held;

  dch_frame_store #(.FRAME_BITS(FRAME_BITS)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (ld_valid_i && !held),
    .wr_bit_i   (ld_bit_i),
    .wr_last_i  (ld_last_i),
    .release_i  (release_buf),
    .rd_idx_i   (cur_idx),
    .rd_bit_o   (rd_bit),
    .len_o      (frame_len),
    .held_o     (held)
  );

  dch_tx_cursor #(.FRAME_BITS(FRAME_BITS), .BUF_BITS(BUF_BITS)) u_cursor (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rewind_i (rewind),
    .step_i   (step),
    .len_i    (frame_len),
    .idx_o    (cur_idx),
    .last_o   (last),
    .early_o  (early)
  );

  dch_arb_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .held_i    (held),
    .sync_i    (sync_i),
    .dslot_i   (dslot_i),
    .grant_i   (grant_i),
    .last_i    (last),
    .early_i   (early),
    .state_o   (fsm_state),
    .rewind_o  (rewind),
    .step_o    (step),
    .release_o (release_buf),
    .tx_en_o   (tx_en),
    .req_o     (req_o),
    .done_o    (done_o),
    .err_o     (err_o)
  );

  assign txd_oe_o = tx_en;
  assign txd_o    = tx_en ? rd_bit : 1'bz;
endmodule

// File: rtl/dch_contention_ctrl_chk.sv
module dch_contention_ctrl_chk
  import dch_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sync_i,
  input logic              grant_i,
  input logic              req_o,
  input logic              done_o,
  input logic              err_o,
  input logic              ld_ready_o,
  input logic              tx_en,
  input dch_state_e        state,
  input logic [ADDR_W-1:0] idx
);
  p_req_falls_at_end_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_o) |-> (done_o || err_o));

  p_start_on_sync_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_SEND && $past(state) != ST_SEND) |-> $past(sync_i && grant_i));

  p_drive_only_requesting_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en |-> req_o);

  p_collision_leaves_send_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_SEND && !grant_i) |=> (state != ST_SEND));

  p_restart_from_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_SEND && $past(state) != ST_SEND) |-> (idx == '0));

  p_err_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  p_err_no_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !req_o);

  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_load_only_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ready_o |-> (state == ST_IDLE));
endmodule

bind dch_contention_ctrl dch_contention_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sync_i     (sync_i),
  .grant_i    (grant_i),
  .req_o      (req_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .ld_ready_o (ld_ready_o),
  .tx_en      (tx_en),
  .state      (fsm_state),
  .idx        (cur_idx)
);

// File: tb/sim_dch_contention_ctrl.sv
`timescale 1ns/100ps
module sim_dch_contention_ctrl;
  localparam int FB = 64;
  localparam int BB = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sync_i = 1'b0, dslot_i = 1'b0, grant_i = 1'b0;
  logic ld_valid_i = 1'b0, ld_bit_i = 1'b0, ld_last_i = 1'b0;
  logic ld_ready_o, req_o, txd_o, txd_oe_o, done_o, err_o;

  dch_contention_ctrl #(.FRAME_BITS(FB), .BUF_BITS(BB)) u0 (.*);

  always #2.5 clk_i = ~clk_i;

  int vectors = 0, misses = 0, cyc = 0;
  int ph = 0, g_base = 0, drop_at = -1, drop_len = 0, drop_cnt = 0;
  int done_cnt = 0, err_cnt = 0;
  bit obs_q[$];
  bit exp_q[$];

  // reference model: 0 idle, 1 request, 2 send, 3 backoff, 4 done
  int m_st = 0, m_idx = 0, m_len = 0;
  bit m_ready = 0, m_err = 0;
  bit m_bits[$];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_idx = 0; m_len = 0; m_ready = 0; m_err = 0; m_bits.delete();
    end else begin
      automatic int  nst = m_st;
      automatic bit  rel = 0, nerr = 0;
      automatic bit  old_ready = m_ready;
      if (!old_ready && ld_valid_i) begin
        m_bits.push_back(ld_bit_i);
        if (ld_last_i || m_bits.size() == FB) begin
          m_ready = 1; m_len = m_bits.size();
        end
      end
      case (m_st)
        0: if (old_ready) nst = 1;
        1, 3: if (sync_i && grant_i) begin nst = 2; m_idx = 0; end
        2: begin
          if (!grant_i) begin
            if (m_idx < 2 * BB) nst = 3;
            else begin nst = 0; nerr = 1; rel = 1; end
          end else if (dslot_i) begin
            if (m_idx == m_len - 1) nst = 4;
            else m_idx++;
          end
        end
        4: begin nst = 0; rel = 1; end
        default: nst = 0;
      endcase
      if (rel) begin m_ready = 0; m_bits.delete(); end
      m_st = nst;
      m_err = nerr;
    end
  end

  task automatic fail(string tag, string what, int act, int exp);
    misses++;
    $display("FAIL %s %s act=%0d exp=%0d at cycle %0d", tag, what, act, exp, cyc);
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) fail(tag, what, act, exp);
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    #1;
    if (rst_ni) begin
      automatic bit e_oe = (m_st == 2) && dslot_i && grant_i;
      automatic string ztag = (m_st == 2 && !grant_i) ? "R5" : "R4";
      chk("R1", "req_o", req_o, (m_st >= 1 && m_st <= 3));
      chk(e_oe ? "R3" : ztag, "txd_oe_o", txd_oe_o, e_oe);
      if (e_oe && txd_oe_o) chk("R3", "txd_o", txd_o, m_bits[m_idx]);
      chk("R8", "done_o", done_o, m_st == 4);
      chk("R7", "err_o", err_o, m_err);
      chk("R9", "ld_ready_o", ld_ready_o, !m_ready);
      if (txd_oe_o) obs_q.push_back(txd_o);
      if (done_o) done_cnt++;
      if (err_o) err_cnt++;
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 150000) begin
      misses++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk_i);
    sync_i  = (ph == 0);
    dslot_i = (ph == 4 || ph == 9);
    ph = (ph + 1) % 12;
    if (drop_at >= 0 && m_st == 2 && m_idx == drop_at) begin
      drop_cnt = drop_len; drop_at = -1;
    end
    grant_i = (drop_cnt > 0) ? 1'b0 : g_base[0];
    if (drop_cnt > 0) drop_cnt--;
  endtask

  task automatic load(int n, int seed, bit use_last);
    exp_q.delete();
    while (!ld_ready_o) tick();
    for (int i = 0; i < n; i++) begin
      tick();
      ld_valid_i = 1'b1;
      ld_bit_i   = ((i * 7 + seed) % 5) < 2;
      ld_last_i  = use_last && (i == n - 1);
      exp_q.push_back(ld_bit_i);
    end
    tick();
    ld_valid_i = 1'b0;
    ld_last_i  = 1'b0;
  endtask

  task automatic run_out();
    for (int i = 0; i < 4000; i++) begin
      tick();
      if (m_st == 0 && !m_ready) break;
    end
    tick(); tick();
  endtask

  task automatic tail_match(string tag);
    automatic int ok = 1;
    if (obs_q.size() < exp_q.size()) ok = 0;
    else
      for (int i = 0; i < exp_q.size(); i++)
        if (obs_q[obs_q.size() - exp_q.size() + i] != exp_q[i]) ok = 0;
    chk(tag, "sent bits match frame", ok, 1);
  endtask

  initial begin
    int d0, e0;
    repeat (3) tick();
    rst_ni = 1'b1;
    tick(); tick();
    chk("R1", "req after reset", req_o, 0);
    chk("R9", "ready after reset", ld_ready_o, 1);
    chk("R4", "oe after reset", txd_oe_o, 0);

    // clean send with grant always present
    g_base = 1; obs_q.delete(); d0 = done_cnt;
    load(20, 3, 1);
    run_out();
    chk("R3", "clean bit count", obs_q.size(), 20);
    tail_match("R3");
    chk("R8", "done pulses", done_cnt - d0, 1);

    // grant rising between syncs must not start
    g_base = 0; obs_q.delete(); d0 = done_cnt;
    load(10, 1, 1);
    while (!(m_st == 1 && ph == 2)) tick();
    g_base = 1;
    repeat (8) tick();
    chk("R2", "bits before next sync", obs_q.size(), 0);
    chk("R1", "req while waiting", req_o, 1);
    run_out();
    chk("R2", "bits after sync", obs_q.size(), 10);
    tail_match("R2");
    chk("R8", "done after late grant", done_cnt - d0, 1);

    // early collision: replay from bit 0
    g_base = 1; obs_q.delete(); d0 = done_cnt; e0 = err_cnt;
    drop_at = 5; drop_len = 30;
    load(24, 2, 1);
    run_out();
    chk("R6", "bits incl replay", obs_q.size(), 29);
    tail_match("R6");
    chk("R6", "done after replay", done_cnt - d0, 1);
    chk("R6", "no error on early hit", err_cnt - e0, 0);

    // collision at the limit: abort
    obs_q.delete(); d0 = done_cnt; e0 = err_cnt;
    drop_at = 2 * BB; drop_len = 10;
    load(50, 4, 1);
    run_out();
    chk("R7", "bits before abort", obs_q.size(), 2 * BB);
    chk("R7", "error pulses", err_cnt - e0, 1);
    chk("R7", "no done on abort", done_cnt - d0, 0);
    chk("R7", "store freed", ld_ready_o, 1);

    // one bit before the limit still retries
    obs_q.delete(); d0 = done_cnt; e0 = err_cnt;
    drop_at = 2 * BB - 1; drop_len = 15;
    load(40, 0, 1);
    run_out();
    chk("R6", "bits incl late replay", obs_q.size(), 2 * BB - 1 + 40);
    chk("R6", "no error below limit", err_cnt - e0, 0);

    // writes while a frame is held are ignored
    g_base = 0; obs_q.delete(); d0 = done_cnt;
    load(8, 1, 1);
    repeat (3) tick();
    for (int i = 0; i < 5; i++) begin
      tick(); ld_valid_i = 1'b1; ld_bit_i = i[0]; ld_last_i = 1'b1;
    end
    tick(); ld_valid_i = 1'b0; ld_last_i = 1'b0;
    chk("R9", "ready low while held", ld_ready_o, 0);
    g_base = 1;
    run_out();
    chk("R9", "bits of held frame", obs_q.size(), 8);
    tail_match("R9");

    // full store commits without a last marker
    obs_q.delete(); d0 = done_cnt;
    load(FB, 2, 0);
    chk("R9", "commit at capacity", ld_ready_o, 0);
    run_out();
    chk("R9", "capacity frame bits", obs_q.size(), FB);
    tail_match("R3");
    chk("R8", "capacity done", done_cnt - d0, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule